// File: doc/BRIEF.md
# Scoreboarded Warp Instruction Issue

This block sits between instruction decode and the execution pipelines of a throughput core that keeps many warps resident at once. Each warp owns one buffer slot that holds a decoded instruction: a destination register, two source registers and a flag that says whether the instruction goes to the memory pipeline or to the ALU pipeline. Each warp also has its own register scoreboard. A pending bit is set when an instruction that writes a register issues, and it is cleared when that register's writeback is reported.

In every cycle the block looks at all occupied slots. A slot is ready when none of the three registers it names is pending in its own warp's scoreboard and its target pipeline is not busy. Among the ready slots, the one that has waited longest wins. Each slot keeps a wait counter, and ties go to the lowest warp index. The winner is sent out registered, together with its warp number, and its slot becomes free at the same clock edge. Because the choice is made again in every cycle with no switching penalty, successive issues can come from different warps. A warp stalled on a memory result does not hold back any other warp.

Top module: `warp_issue_top`

## Requirements
- R1: After reset, all slots are empty (`slotFull` is 0), all scoreboard bits are clear, all wait counters are 0, and `issueValid` is 0.
- R2: A fetch with `fetchValid` high loads the slot of `fetchWarp` only if that slot is empty at the clock edge. `slotFull` for that warp rises after that edge. A fetch to an occupied slot, or to a warp number of `NUM_WARPS` or above, is ignored and leaves the held instruction unchanged.
- R3: A slot can be chosen only when its warp's pending bits for `SrcA`, `SrcB` and `Dst` are all clear.
- R4: An issue sets the pending bit of (warp, `Dst`). A writeback with `wbValid` clears (`wbWarp`, `wbReg`) at the clock edge, so the operand counts as clear from the next cycle. A second write to a still-pending destination (write after write) is therefore held.
- R5: A slot whose `isMem` flag is 1 is not chosen while `memBusy` is high, and a slot whose flag is 0 is not chosen while `aluBusy` is high. Such a slot stays loaded, and slots bound for the other pipeline can still issue.
- R6: At most one instruction issues per clock edge, and one always issues when any slot is ready. Issue outputs are registered: they appear in the cycle after the choice, and the chosen slot is empty from that same edge. Consecutive cycles may issue from different warps with no gap.
- R7: Each slot has a wait counter of `AGE_W` bits. It is 0 after the slot issues and counts up by one per edge while the slot is occupied and not chosen, stopping at its maximum. The ready slot with the largest count wins, and on equal counts the lowest warp index wins.
- R8: Scoreboards are kept per warp. A pending register in one warp does not block another warp that uses the same register number.
- R9: With default parameters, 24 warps (indices 0 to 23) can hold instructions and compete for issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | A decoded instruction is offered this cycle |
| fetchWarp | input | WID_W | Warp that owns the offered instruction |
| fetchIsMem | input | 1 | 1: memory pipeline, 0: ALU pipeline |
| fetchDst | input | REG_W | Destination register |
| fetchSrcA | input | REG_W | First source register |
| fetchSrcB | input | REG_W | Second source register |
| wbValid | input | 1 | Register writeback notification |
| wbWarp | input | WID_W | Warp of the written register |
| wbReg | input | REG_W | Written register number |
| aluBusy | input | 1 | ALU pipeline cannot accept an issue |
| memBusy | input | 1 | Memory pipeline cannot accept an issue |
| slotFull | output | NUM_WARPS | Per-warp slot occupancy |
| issueValid | output | 1 | An instruction issued at the last edge |
| issueWarp | output | WID_W | Warp of the issued instruction |
| issueIsMem | output | 1 | Target pipeline of the issued instruction |
| issueDst | output | REG_W | Destination of the issued instruction |
| issueSrcA | output | REG_W | First source of the issued instruction |
| issueSrcB | output | REG_W | Second source of the issued instruction |

## Verification
Issue and writeback can act at the same clock edge. They may touch the same warp's scoreboard or even the same bit, and a fetch can refill one slot while another slot drains. A random phase sends a writeback in most cycles, aimed at bits the model knows are pending, while fetches and busy signals keep the issue path active. The behavioural model then judges, cycle by cycle, that a cleared operand becomes usable only one cycle after its writeback and that a newly set pending bit is never lost to a writeback in the same cycle. Directed cases cover the age tie at counter saturation, write-after-write holding, a fetch to an occupied slot, and one pipeline busy while the other is free.

// File: rtl/warp_issue_pkg.sv
package warp_issue_pkg;
  // widest warp index the strobe struct can carry
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             load;
    logic [IDX_W-1:0] loadIdx;
    logic             fire;
    logic [IDX_W-1:0] fireIdx;
  } issueStrobe_t;
endpackage

// File: rtl/warp_issue_dp.sv
module warp_issue_dp
  import warp_issue_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int NUM_REGS  = 32,
  parameter int AGE_W     = 6,
  localparam int WID_W    = $clog2(NUM_WARPS),
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  issueStrobe_t                         strb,
  input  logic                                 fetchIsMem,
  input  logic [REG_W-1:0]                     fetchDst,
  input  logic [REG_W-1:0]                     fetchSrcA,
  input  logic [REG_W-1:0]                     fetchSrcB,
  input  logic                                 wbValid,
  input  logic [WID_W-1:0]                     wbWarp,
  input  logic [REG_W-1:0]                     wbReg,
  output logic [NUM_WARPS-1:0]                 slotValid,
  output logic [NUM_WARPS-1:0]                 slotIsMem,
  output logic [NUM_WARPS-1:0][REG_W-1:0]      slotDst,
  output logic [NUM_WARPS-1:0][REG_W-1:0]      slotSrcA,
  output logic [NUM_WARPS-1:0][REG_W-1:0]      slotSrcB,
  output logic [NUM_WARPS-1:0][NUM_REGS-1:0]   pending,
  output logic [NUM_WARPS-1:0][AGE_W-1:0]      age,
  output logic                                 issueValid,
  output logic [WID_W-1:0]                     issueWarp,
  output logic                                 issueIsMem,
  output logic [REG_W-1:0]                     issueDst,
  output logic [REG_W-1:0]                     issueSrcA,
  output logic [REG_W-1:0]                     issueSrcB
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic [WID_W-1:0] fireW;
  assign fireW = strb.fireIdx[WID_W-1:0];

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    logic hitFire, hitLoad;
    logic [NUM_REGS-1:0] pendNext;
    assign hitFire = strb.fire && (strb.fireIdx == IDX_W'(w));
    assign hitLoad = strb.load && (strb.loadIdx == IDX_W'(w));

    // instruction slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotValid[w] <= 1'b0;
        slotIsMem[w] <= 1'b0;
        slotDst[w]   <= '0;
        slotSrcA[w]  <= '0;
        slotSrcB[w]  <= '0;
      end else if (hitFire) begin
        slotValid[w] <= 1'b0;
      end else if (hitLoad) begin
        slotValid[w] <= 1'b1;
        slotIsMem[w] <= fetchIsMem;
        slotDst[w]   <= fetchDst;
        slotSrcA[w]  <= fetchSrcA;
        slotSrcB[w]  <= fetchSrcB;
      end
    end

    // wait counter: zero on issue, saturating count while waiting
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  age[w] <= '0;
      else if (hitFire)                           age[w] <= '0;
      else if (slotValid[w] && age[w] != AGE_MAX) age[w] <= age[w] + 1'b1;
    end

    // per-warp scoreboard: writeback clears, issue sets (set wins)
    always_comb begin
      pendNext = pending[w];
      if (wbValid && wbWarp == WID_W'(w)) pendNext[wbReg] = 1'b0;
      if (hitFire) pendNext[slotDst[w]] = 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pending[w] <= '0;
      else       pending[w] <= pendNext;
    end

    // R2: a held instruction is never overwritten while it waits
    p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      slotValid[w] |=> (!slotValid[w] || $stable(slotDst[w])));
  end

  // registered issue port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      issueValid <= 1'b0;
      issueWarp  <= '0;
      issueIsMem <= 1'b0;
      issueDst   <= '0;
      issueSrcA  <= '0;
      issueSrcB  <= '0;
    end else begin
      issueValid <= strb.fire;
      if (strb.fire) begin
        issueWarp  <= fireW;
        issueIsMem <= slotIsMem[fireW];
        issueDst   <= slotDst[fireW];
        issueSrcA  <= slotSrcA[fireW];
        issueSrcB  <= slotSrcB[fireW];
      end
    end
  end

  // R4: the issued destination is pending right after issue
  p_dst_marked_r4: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> pending[issueWarp][issueDst]);

  // R6: the issuing slot is empty once the issue is visible
  p_slot_drained_r6: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> !slotValid[issueWarp]);

  // R7: the wait counter restarts from zero on issue
  p_age_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (age[issueWarp] == '0));
endmodule

// File: rtl/warp_issue_ctl.sv
module warp_issue_ctl
  import warp_issue_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int NUM_REGS  = 32,
  parameter int AGE_W     = 6,
  localparam int WID_W    = $clog2(NUM_WARPS),
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 fetchValid,
  input  logic [WID_W-1:0]                     fetchWarp,
  input  logic                                 aluBusy,
  input  logic                                 memBusy,
  input  logic [NUM_WARPS-1:0]                 slotValid,
  input  logic [NUM_WARPS-1:0]                 slotIsMem,
  input  logic [NUM_WARPS-1:0][REG_W-1:0]      slotDst,
  input  logic [NUM_WARPS-1:0][REG_W-1:0]      slotSrcA,
  input  logic [NUM_WARPS-1:0][REG_W-1:0]      slotSrcB,
  input  logic [NUM_WARPS-1:0][NUM_REGS-1:0]   pending,
  input  logic [NUM_WARPS-1:0][AGE_W-1:0]      age,
  output issueStrobe_t                         strb
);
  logic [NUM_WARPS-1:0] ready;
  logic                 found;
  logic [AGE_W-1:0]     bestAge;
  logic [WID_W-1:0]     selIdx;
  logic                 fetchInRange;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_ready
    logic opClear, pipeFree;
    assign opClear  = !pending[w][slotSrcA[w]] && !pending[w][slotSrcB[w]]
                   && !pending[w][slotDst[w]];
    assign pipeFree = slotIsMem[w] ? !memBusy : !aluBusy;
    assign ready[w] = slotValid[w] && opClear && pipeFree;
  end

  // oldest ready slot; strict compare keeps the lowest index on ties
  always_comb begin
    found   = 1'b0;
    bestAge = '0;
    selIdx  = '0;
    for (int w = 0; w < NUM_WARPS; w++) begin
      if (ready[w] && (!found || age[w] > bestAge)) begin
        found   = 1'b1;
        bestAge = age[w];
        selIdx  = WID_W'(w);
      end
    end
  end

  assign fetchInRange = int'(fetchWarp) < NUM_WARPS;

  always_comb begin
    strb.fire    = found;
    strb.fireIdx = IDX_W'(selIdx);
    strb.load    = fetchValid && fetchInRange && !slotValid[fetchWarp];
    strb.loadIdx = IDX_W'(fetchWarp);
  end

  // R3: every operand of the chosen slot is clear in its warp
  p_operands_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |-> (!pending[selIdx][slotSrcA[selIdx]] && !pending[selIdx][slotSrcB[selIdx]]
                   && !pending[selIdx][slotDst[selIdx]]));

  // R5: never choose a slot whose pipeline reports busy
  p_pipe_free_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |-> !(slotIsMem[selIdx] ? memBusy : aluBusy));

  // R6: some ready slot always leads to an issue
  p_no_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|ready) |-> strb.fire);

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_order
    // R7: no ready slot is older than the winner
    p_oldest_r7: assert property (@(posedge clk) disable iff (!rstN)
      (strb.fire && ready[w]) |-> (age[w] <= age[selIdx]));
    // R7: on equal age the lower index wins
    p_tie_low_r7: assert property (@(posedge clk) disable iff (!rstN)
      (strb.fire && ready[w] && age[w] == age[selIdx]) |-> (int'(selIdx) <= w));
  end
endmodule

// File: rtl/warp_issue_top.sv
module warp_issue_top
  import warp_issue_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  parameter int NUM_REGS  = 32,
  parameter int AGE_W     = 6,
  localparam int WID_W    = $clog2(NUM_WARPS),
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fetchValid,
  input  logic [WID_W-1:0]     fetchWarp,
  input  logic                 fetchIsMem,
  input  logic [REG_W-1:0]     fetchDst,
  input  logic [REG_W-1:0]     fetchSrcA,
  input  logic [REG_W-1:0]     fetchSrcB,
  input  logic                 wbValid,
  input  logic [WID_W-1:0]     wbWarp,
  input  logic [REG_W-1:0]     wbReg,
  input  logic                 aluBusy,
  input  logic                 memBusy,
  output logic [NUM_WARPS-1:0] slotFull,
  output logic                 issueValid,
  output logic [WID_W-1:0]     issueWarp,
  output logic                 issueIsMem,
  output logic [REG_W-1:0]     issueDst,
  output logic [REG_W-1:0]     issueSrcA,
  output logic [REG_W-1:0]     issueSrcB
);
  issueStrobe_t                         strb;
  logic [NUM_WARPS-1:0]                 slotValid;
  logic [NUM_WARPS-1:0]                 slotIsMem;
  logic [NUM_WARPS-1:0][REG_W-1:0]      slotDst, slotSrcA, slotSrcB;
  logic [NUM_WARPS-1:0][NUM_REGS-1:0]   pending;
  logic [NUM_WARPS-1:0][AGE_W-1:0]      age;

  initial begin
    if (NUM_WARPS < 2 || NUM_WARPS > (1 << IDX_W)) $error("NUM_WARPS out of range");
  end

  warp_issue_ctl #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .AGE_W(AGE_W)) i_ctl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchWarp(fetchWarp),
    .aluBusy(aluBusy), .memBusy(memBusy), .slotValid(slotValid), .slotIsMem(slotIsMem),
    .slotDst(slotDst), .slotSrcA(slotSrcA), .slotSrcB(slotSrcB), .pending(pending),
    .age(age), .strb(strb));

  warp_issue_dp #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .AGE_W(AGE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fetchIsMem(fetchIsMem), .fetchDst(fetchDst),
    .fetchSrcA(fetchSrcA), .fetchSrcB(fetchSrcB), .wbValid(wbValid), .wbWarp(wbWarp),
    .wbReg(wbReg), .slotValid(slotValid), .slotIsMem(slotIsMem), .slotDst(slotDst),
    .slotSrcA(slotSrcA), .slotSrcB(slotSrcB), .pending(pending), .age(age),
    .issueValid(issueValid), .issueWarp(issueWarp), .issueIsMem(issueIsMem),
    .issueDst(issueDst), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB));

  assign slotFull = slotValid;
endmodule

// File: tb/test_warp_issue_top.sv
`timescale 1ns/1ps
module test_warp_issue_top;
  localparam int NW = 24;
  localparam int NR = 32;
  localparam int AMAX = 63;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchValid = 0, fetchIsMem = 0, wbValid = 0, aluBusy = 0, memBusy = 0;
  logic [4:0] fetchWarp = 0, fetchDst = 0, fetchSrcA = 0, fetchSrcB = 0, wbWarp = 0, wbReg = 0;
  logic [NW-1:0] slotFull;
  logic issueValid, issueIsMem;
  logic [4:0] issueWarp, issueDst, issueSrcA, issueSrcB;

  always #2 clk = ~clk;

  warp_issue_top i_warp_issue_top (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchWarp(fetchWarp),
    .fetchIsMem(fetchIsMem), .fetchDst(fetchDst), .fetchSrcA(fetchSrcA),
    .fetchSrcB(fetchSrcB), .wbValid(wbValid), .wbWarp(wbWarp), .wbReg(wbReg),
    .aluBusy(aluBusy), .memBusy(memBusy), .slotFull(slotFull), .issueValid(issueValid),
    .issueWarp(issueWarp), .issueIsMem(issueIsMem), .issueDst(issueDst),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB));

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural reference model
  bit mValid[NW];
  bit mMem[NW];
  int mD[NW], mA[NW], mB[NW], mAge[NW];
  bit mPend[NW][NR];
  bit expV;
  int expW, expD, expA, expB;
  bit expM;
  int sel, best;
  bit rdy, ld;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < NW; w++) begin
        mValid[w] = 0; mAge[w] = 0;
        for (int r = 0; r < NR; r++) mPend[w][r] = 0;
      end
      expV = 0;
    end else begin
      sel = -1; best = -1;
      for (int w = 0; w < NW; w++) begin
        rdy = mValid[w] && !mPend[w][mA[w]] && !mPend[w][mB[w]] && !mPend[w][mD[w]]
              && !(mMem[w] ? memBusy : aluBusy);
        if (rdy && mAge[w] > best) begin best = mAge[w]; sel = w; end
      end
      ld = fetchValid && (int'(fetchWarp) < NW) && !mValid[fetchWarp];
      expV = (sel >= 0);
      if (sel >= 0) begin
        expW = sel; expM = mMem[sel]; expD = mD[sel]; expA = mA[sel]; expB = mB[sel];
      end
      for (int w = 0; w < NW; w++) begin
        if (w == sel) mAge[w] = 0;
        else if (mValid[w] && mAge[w] < AMAX) mAge[w]++;
      end
      if (wbValid && int'(wbWarp) < NW) mPend[wbWarp][wbReg] = 0;
      if (sel >= 0) begin mPend[sel][mD[sel]] = 1; mValid[sel] = 0; end
      if (ld) begin
        mValid[fetchWarp] = 1; mMem[fetchWarp] = fetchIsMem; mD[fetchWarp] = fetchDst;
        mA[fetchWarp] = fetchSrcA; mB[fetchWarp] = fetchSrcB;
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(issueValid == expV, "R6 issueValid vs model", issueValid, expV);
      if (expV && issueValid) begin
        chk(issueWarp == expW[4:0], "R7 issueWarp vs model", issueWarp, expW);
        chk(issueIsMem == expM, "R5 issueIsMem vs model", issueIsMem, expM);
        chk(issueDst == expD[4:0] && issueSrcA == expA[4:0] && issueSrcB == expB[4:0],
            "R2 issued fields vs model", issueDst, expD);
      end
      for (int w = 0; w < NW; w++)
        chk(slotFull[w] == mValid[w], "R2 slotFull vs model", slotFull[w], mValid[w]);
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doFetch(int w, bit mem, int d, int a, int b);
    fetchValid = 1; fetchWarp = w[4:0]; fetchIsMem = mem;
    fetchDst = d[4:0]; fetchSrcA = a[4:0]; fetchSrcB = b[4:0];
    step();
    fetchValid = 0;
  endtask

  task automatic doWb(int w, int r);
    wbValid = 1; wbWarp = w[4:0]; wbReg = r[4:0];
    step();
    wbValid = 0;
  endtask

  task automatic expIssue(string tag, int w, int d);
    chk(issueValid == 1, tag, issueValid, 1);
    chk(issueWarp == w[4:0], tag, issueWarp, w);
    chk(issueDst == d[4:0], tag, issueDst, d);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(slotFull == '0, "R1 reset slots empty", slotFull, 0);
    chk(issueValid == 0, "R1 reset no issue", issueValid, 0);
    rstN = 1;
    @(negedge clk);

    // basic load and issue
    doFetch(3, 0, 5, 1, 2);
    chk(slotFull[3] == 1, "R2 slot loaded", slotFull[3], 1);
    chk(issueValid == 0, "R6 issue latency", issueValid, 0);
    step();
    expIssue("R6 first issue", 3, 5);

    // RAW hazard, other warp unaffected, writeback release
    doFetch(3, 0, 8, 5, 1);
    step();
    chk(issueValid == 0, "R3 raw blocked", issueValid, 0);
    doFetch(7, 0, 6, 5, 5);
    chk(issueValid == 0, "R3 still blocked", issueValid, 0);
    step();
    expIssue("R8 independent scoreboard", 7, 6);
    doWb(3, 5);
    chk(issueValid == 0, "R4 clear visible next cycle", issueValid, 0);
    step();
    expIssue("R4 release after writeback", 3, 8);

    // write after write
    doFetch(4, 0, 9, 0, 0);
    step();
    expIssue("R4 first write", 4, 9);
    doFetch(4, 0, 9, 1, 1);
    step();
    chk(issueValid == 0, "R4 waw held", issueValid, 0);
    doWb(4, 9);
    step();
    expIssue("R4 waw released", 4, 9);

    // decoupled pipelines
    memBusy = 1;
    doFetch(1, 1, 2, 3, 3);
    doFetch(2, 0, 2, 3, 3);
    chk(issueValid == 0, "R5 mem held", issueValid, 0);
    step();
    expIssue("R5 alu passes busy mem", 2, 2);
    step();
    chk(issueValid == 0 && slotFull[1] == 1, "R5 mem stays in slot", slotFull[1], 1);
    memBusy = 0;
    step();
    expIssue("R5 mem issues when free", 1, 2);
    chk(issueIsMem == 1, "R5 mem flag", issueIsMem, 1);

    // age order
    aluBusy = 1;
    doFetch(12, 0, 1, 0, 0);
    doFetch(10, 0, 1, 0, 0);
    aluBusy = 0;
    step();
    expIssue("R7 older wins", 12, 1);
    step();
    expIssue("R7 younger next", 10, 1);

    // saturated tie goes to lowest index
    aluBusy = 1;
    doFetch(14, 0, 4, 0, 0);
    doFetch(11, 0, 4, 0, 0);
    repeat (70) step();
    aluBusy = 0;
    step();
    expIssue("R7 tie lowest index", 11, 4);
    step();
    expIssue("R7 tie second", 14, 4);

    // fetch to occupied slot ignored
    aluBusy = 1;
    doFetch(5, 0, 20, 0, 0);
    doFetch(5, 0, 21, 0, 0);
    aluBusy = 0;
    step();
    expIssue("R2 occupied fetch ignored", 5, 20);
    step();
    chk(issueValid == 0 && slotFull[5] == 0, "R2 no second instruction", slotFull[5], 0);

    // highest warp index
    doFetch(23, 1, 3, 0, 0);
    step();
    expIssue("R9 warp 23", 23, 3);

    // random traffic with overlapping writeback and issue
    for (int c = 0; c < 4000; c++) begin
      int w, off;
      bit hit;
      fetchValid = ($urandom_range(0, 3) != 0);
      fetchWarp  = 5'($urandom_range(0, NW - 1));
      fetchIsMem = $urandom_range(0, 1) == 1;
      fetchDst   = 5'($urandom_range(0, 7));
      fetchSrcA  = 5'($urandom_range(0, 7));
      fetchSrcB  = 5'($urandom_range(0, 7));
      aluBusy    = ($urandom_range(0, 3) == 0);
      memBusy    = ($urandom_range(0, 3) == 0);
      wbValid    = ($urandom_range(0, 4) != 0);
      w = $urandom_range(0, NW - 1);
      off = $urandom_range(0, 7);
      hit = 0;
      wbWarp = w[4:0];
      wbReg = off[4:0];
      for (int k = 0; k < 8; k++)
        if (!hit && mPend[w][(off + k) % 8]) begin hit = 1; wbReg = 5'((off + k) % 8); end
      step();
    end
    fetchValid = 0; wbValid = 0; aluBusy = 0; memBusy = 0;
    step();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule